// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a 5-row by 6-column key matrix and scans it only when the pattern on the columns shows that a key went down or came up. While it is idle, every row output sits low. A pressed key then pulls its column low. The block compares the column pattern with the column pattern implied by its stored key state. When the two differ, it starts walking a single low row across the matrix, from the first row to the fifth. At the end of each row pulse it samples the six active-low columns into a 30-bit key state. It also emits a one-cycle wake request, which a sleep controller can use.

After the first complete pass over all five rows, the interrupt output rises. It stays high while scanning continues, until a stop pulse arrives from the serial front end. The stop pulse returns all rows low. If the key state changed during a row sample taken after the interrupt rose, the next stop pulse is spent re-arming the stop, and a second stop pulse is needed.

A read pulse has two effects. It copies the key state in parallel into a snapshot register for the serial shifter, and it drops the interrupt. While scanning, it also restarts the row walk, so the interrupt rises again after a full pass. Column inputs are taken as already synchronous, and no debounce filtering is applied.

Top module: `key_scanner`

## Requirements
- R1: While reset is active and on the first cycle after it, all row outputs are low, the interrupt is low, the wake request is low, and the snapshot is zero.
- R2: While idle, all row outputs stay low, and no scan starts as long as the inverted column pattern equals the OR over all rows of the stored key state.
- R3: In the idle state, a mismatch under R2 (a press or a release) starts scanning on the next clock edge. On that same edge, the wake request goes high for exactly one cycle.
- R4: While scanning, exactly one row output is low and the others are high. Rows are visited in order 1 to 5, each for ROW_TICKS cycles, and the walk wraps back to row 1.
- R5: On the last cycle of each row pulse, the inverted columns are stored in the key state. Row r, column c (both counted from 1) sits at bit (r-1)*6+(c-1), and 1 means the key is pressed.
- R6: The interrupt rises on the edge that samples row 5 of the first pass. The count is ROWS*ROW_TICKS edges after the edge that started the scan, so the first high value appears 5*ROW_TICKS+1 edges after the column change is applied.
- R7: Once high, the interrupt stays high through later passes until a stop takes effect or a read pulse arrives.
- R8: A stop pulse during scanning with no pending re-arm returns all rows low and clears the interrupt on that edge.
- R9: While the interrupt is high, a row sample that differs from the stored row sets a re-arm. The next stop pulse only clears the re-arm and scanning continues. The stop pulse after that ends the scan.
- R10: A stop pulse while idle has no effect: the rows stay low, and the interrupt and the wake request stay low.
- R11: A read pulse loads the key state into the snapshot and clears the interrupt on that edge. During scanning it restarts the walk at row 1, and the interrupt rises again 5*ROW_TICKS edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| colN | input | COLS | Column returns, low when a key on a driven row is pressed |
| stopPulse | input | 1 | One-cycle stop command |
| readPulse | input | 1 | One-cycle read command (load snapshot, clear interrupt) |
| rowOut | output | ROWS | Row drive levels; low means driven |
| irq | output | 1 | Interrupt, high after the first full pass |
| wakeReq | output | 1 | One-cycle pulse when a scan starts |
| keySnapshot | output | ROWS*COLS | Parallel key state captured by the read pulse |

## Verification
The row walk and the wake request show up on the first edge after a column change, because only the registered scan state and row index stand between them. Each row lasts ROW_TICKS edges, so the interrupt is due exactly 5*ROW_TICKS+1 edges after the change is applied. The same count applies after a read pulse. Stop pulses, read pulses and the snapshot take effect on their own edge. The bench drives every input on a falling edge and counts whole rising edges before it samples. It checks the interrupt on both sides of the edge where it is due: one edge early it must be low, and on the due edge it must be high.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic sampleRow;  // store the inverted columns into the current row
    logic loadSnap;   // copy the key state into the snapshot
  } kscanStrobes_t;
endpackage

// File: rtl/kscan_dp.sv
module kscan_dp
  import kscan_pkg::*;
#(
  parameter int ROWS = 5,
  parameter int COLS = 6,
  localparam int KEYS = ROWS * COLS,
  localparam int RIDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COLS-1:0]   colN,
  input  kscanStrobes_t     strobes,
  input  logic [RIDX_W-1:0] rowIdx,
  output logic [KEYS-1:0]   keySnapshot,
  output logic              idleChange,
  output logic              rowDiff
);
  logic [KEYS-1:0] keyState;
  logic [COLS-1:0] colSeen;
  logic [COLS-1:0] storedRow;

  // With every row low, a column reads pressed if any stored row has it.
  always_comb begin
    colSeen = '0;
    for (int r = 0; r < ROWS; r++) colSeen |= keyState[r*COLS +: COLS];
    storedRow  = keyState[int'(rowIdx)*COLS +: COLS];
    idleChange = (~colN != colSeen);
    rowDiff    = (~colN != storedRow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState    <= '0;
      keySnapshot <= '0;
    end else begin
      if (strobes.sampleRow) keyState[int'(rowIdx)*COLS +: COLS] <= ~colN;
      if (strobes.loadSnap)  keySnapshot <= keyState;
    end
  end
endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int ROWS = 5,
  parameter int ROW_TICKS = 1560,
  localparam int RIDX_W = $clog2(ROWS),
  localparam int TICK_W = $clog2(ROW_TICKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopPulse,
  input  logic              readPulse,
  input  logic              idleChange,
  input  logic              rowDiff,
  output kscanStrobes_t     strobes,
  output logic [RIDX_W-1:0] rowIdx,
  output logic              scanning,
  output logic              irq,
  output logic              wakeReq,
  output logic              rearm
);
  logic [TICK_W-1:0] tickCnt;
  logic lastTick, stopNow, startScan;

  always_comb begin
    lastTick          = scanning && (tickCnt == TICK_W'(ROW_TICKS - 1));
    stopNow           = scanning && stopPulse && !rearm;
    startScan         = !scanning && idleChange;
    strobes.sampleRow = lastTick && !stopNow && !readPulse;
    strobes.loadSnap  = readPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanning <= 1'b0;
      irq      <= 1'b0;
      wakeReq  <= 1'b0;
      rearm    <= 1'b0;
      tickCnt  <= '0;
      rowIdx   <= '0;
    end else begin
      wakeReq <= startScan;
      if (!scanning) begin
        if (startScan) begin
          scanning <= 1'b1;
          tickCnt  <= '0;
          rowIdx   <= '0;
        end
      end else if (stopNow) begin
        scanning <= 1'b0;
        irq      <= 1'b0;
        tickCnt  <= '0;
        rowIdx   <= '0;
      end else begin
        if (stopPulse) rearm <= 1'b0;  // stop spent on the re-arm
        if (readPulse) begin
          irq     <= 1'b0;
          tickCnt <= '0;
          rowIdx  <= '0;
        end else if (lastTick) begin
          tickCnt <= '0;
          if (rowDiff && irq) rearm <= 1'b1;
          if (rowIdx == RIDX_W'(ROWS - 1)) begin
            rowIdx <= '0;
            irq    <= 1'b1;
          end else begin
            rowIdx <= rowIdx + 1'b1;
          end
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/key_scanner.sv
module key_scanner
  import kscan_pkg::*;
#(
  parameter int ROWS = 5,
  parameter int COLS = 6,
  parameter int ROW_TICKS = 1560,
  localparam int KEYS = ROWS * COLS,
  localparam int RIDX_W = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [COLS-1:0] colN,
  input  logic            stopPulse,
  input  logic            readPulse,
  output logic [ROWS-1:0] rowOut,
  output logic            irq,
  output logic            wakeReq,
  output logic [KEYS-1:0] keySnapshot
);
  kscanStrobes_t     strobes;
  logic [RIDX_W-1:0] rowIdx;
  logic              scanning, rearm, idleChange, rowDiff;

  kscan_ctrl #(.ROWS(ROWS), .ROW_TICKS(ROW_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .stopPulse(stopPulse), .readPulse(readPulse),
    .idleChange(idleChange), .rowDiff(rowDiff), .strobes(strobes),
    .rowIdx(rowIdx), .scanning(scanning), .irq(irq), .wakeReq(wakeReq),
    .rearm(rearm)
  );

  kscan_dp #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk(clk), .rstN(rstN), .colN(colN), .strobes(strobes), .rowIdx(rowIdx),
    .keySnapshot(keySnapshot), .idleChange(idleChange), .rowDiff(rowDiff)
  );

  // Driven row low, all others high; all low while idle.
  assign rowOut = scanning ? ~(ROWS'(1) << rowIdx) : '0;
endmodule

// File: rtl/key_scanner_chk.sv
module key_scanner_chk #(
  parameter int ROWS = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic [ROWS-1:0] rowOut,
  input logic            irq,
  input logic            wakeReq,
  input logic            stopPulse,
  input logic            readPulse,
  input logic            scanning,
  input logic            rearm
);
  p_one_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rowOut == '0) || ($countones(~rowOut) == 1));

  p_irq_scanning_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (scanning && rowOut != '0));

  p_irq_after_last_row_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(rowOut) == ~(ROWS'(1) << (ROWS - 1))));

  p_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && stopPulse && !rearm) |=> (rowOut == '0 && !irq));

  p_rearm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && stopPulse && rearm) |=> scanning);

  p_idle_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!scanning && stopPulse) |=> !irq);

  p_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    readPulse |=> !irq);

  p_wake_r3: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ($past(rowOut) == '0 && scanning));
endmodule

bind key_scanner key_scanner_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .rowOut(rowOut), .irq(irq), .wakeReq(wakeReq),
  .stopPulse(stopPulse), .readPulse(readPulse), .scanning(scanning),
  .rearm(rearm)
);

// File: tb/test_key_scanner.sv
module test_key_scanner;
  localparam int ROWS = 5;
  localparam int COLS = 6;
  localparam int RT = 4;
  localparam int PASS_EDGES = ROWS * RT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [COLS-1:0] colN;
  logic stopPulse = 1'b0;
  logic readPulse = 1'b0;
  logic [ROWS-1:0] rowOut;
  logic irq, wakeReq;
  logic [ROWS*COLS-1:0] keySnapshot;
  logic [ROWS*COLS-1:0] pressed = '0;
  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  key_scanner #(.ROWS(ROWS), .COLS(COLS), .ROW_TICKS(RT)) i_key_scanner (
    .clk(clk), .rstN(rstN), .colN(colN), .stopPulse(stopPulse),
    .readPulse(readPulse), .rowOut(rowOut), .irq(irq), .wakeReq(wakeReq),
    .keySnapshot(keySnapshot)
  );

  // Matrix model: a pressed key on a low row pulls its column low.
  always_comb begin
    colN = '1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (!rowOut[r] && pressed[r*COLS+c]) colN[c] = 1'b0;
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseStop();
    stopPulse = 1'b1;
    step(1);
    stopPulse = 1'b0;
  endtask

  task automatic pulseRead();
    readPulse = 1'b1;
    step(1);
    readPulse = 1'b0;
  endtask

  function automatic logic [31:0] rowPat(int idx);
    return 32'(~(5'b1 << idx) & 5'h1f);
  endfunction

  task automatic tReset();
    check("R1", "rows in reset", 32'(rowOut), 0);
    check("R1", "irq in reset", 32'(irq), 0);
    rstN = 1'b1;
    step(1);
    check("R1", "rows after reset", 32'(rowOut), 0);
    check("R1", "wake after reset", 32'(wakeReq), 0);
    check("R1", "snapshot after reset", 32'(keySnapshot), 0);
  endtask

  task automatic tIdle();
    step(10);
    check("R2", "rows idle", 32'(rowOut), 0);
    check("R2", "irq idle", 32'(irq), 0);
  endtask

  task automatic tPressScan();
    int bad = 0;
    pressed[8] = 1'b1;  // row 2, column 3
    step(1);
    check("R3", "wake on press", 32'(wakeReq), 1);
    check("R4", "row 1 first", 32'(rowOut), rowPat(0));
    for (int k = 2; k <= PASS_EDGES; k++) begin
      step(1);
      if (k == 2 && wakeReq !== 1'b0) bad++;
      if (rowOut !== rowPat((k - 1) / RT)) bad++;
    end
    check("R4", "row walk mismatches", 32'(bad), 0);
    check("R6", "irq one edge early", 32'(irq), 0);
    step(1);
    check("R6", "irq after full pass", 32'(irq), 1);
    check("R4", "walk wraps to row 1", 32'(rowOut), rowPat(0));
    step(PASS_EDGES);
    check("R7", "irq held on later pass", 32'(irq), 1);
  endtask

  task automatic tRead();
    pulseRead();
    check("R5", "snapshot row2 col3", 32'(keySnapshot), 32'h100);
    check("R11", "irq cleared by read", 32'(irq), 0);
    check("R11", "walk restarts", 32'(rowOut), rowPat(0));
    step(PASS_EDGES - 1);
    check("R11", "irq low before pass end", 32'(irq), 0);
    step(1);
    check("R11", "irq back after pass", 32'(irq), 1);
  endtask

  task automatic tStop();
    pulseStop();
    check("R8", "rows low after stop", 32'(rowOut), 0);
    check("R8", "irq low after stop", 32'(irq), 0);
    step(10);
    check("R2", "no restart on held key", 32'(rowOut), 0);
  endtask

  task automatic tIdleStop();
    pulseStop();
    check("R10", "rows after idle stop", 32'(rowOut), 0);
    check("R10", "irq after idle stop", 32'(irq), 0);
    check("R10", "wake after idle stop", 32'(wakeReq), 0);
  endtask

  task automatic tRelease();
    pressed[8] = 1'b0;
    step(1);
    check("R3", "wake on release", 32'(wakeReq), 1);
    step(PASS_EDGES);
    check("R6", "irq after release pass", 32'(irq), 1);
    pulseRead();
    check("R5", "snapshot after release", 32'(keySnapshot), 0);
    pulseStop();
    check("R8", "stop after release", 32'(rowOut), 0);
  endtask

  task automatic tMulti();
    pressed[0] = 1'b1; pressed[29] = 1'b1; pressed[15] = 1'b1; pressed[12] = 1'b1;
    step(PASS_EDGES + 1);
    check("R6", "irq multi-key", 32'(irq), 1);
    pulseRead();
    check("R5", "snapshot multi-key", 32'(keySnapshot), 32'h2000_9001);
    pulseStop();
    check("R8", "stop multi-key", 32'(rowOut), 0);
  endtask

  task automatic tRearm();
    pressed[15] = 1'b0;
    step(PASS_EDGES + 1);
    check("R6", "irq before rearm", 32'(irq), 1);
    pressed[20] = 1'b1;  // row 4, column 3, while irq is high
    step(PASS_EDGES + RT);
    pulseStop();
    check("R9", "first stop keeps scanning", 32'(rowOut != '0), 1);
    check("R9", "first stop keeps irq", 32'(irq), 1);
    pulseStop();
    check("R9", "second stop ends scan", 32'(rowOut), 0);
    check("R9", "second stop clears irq", 32'(irq), 0);
    step(5);
    check("R2", "idle after rearm stop", 32'(rowOut), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    tIdle();
    tPressScan();
    tRead();
    tStop();
    tIdleStop();
    tRelease();
    tMulti();
    tRearm();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(100000 * 8);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule